// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clock source feeds the system clock and which peripheral clocks keep running while a microcontroller sits in one of two low-power modes, STOP and HALT. Its rules make sure that the part can always return to RUN without a reset. The clock used by the pin and external-interrupt logic is never gated. The internal RC oscillator (IRC) stays powered in both low-power modes, because the glitch filters on the interrupt-capable pins run from it. The system clock selector can only ever settle on a source that is actually running.

A mode request is issued from RUN with a one-cycle strobe. On STOP entry the block saves the current source and switches to the IRC. On HALT entry it keeps the current source, and that source may then be changed only to another running source. A wake-up can come from three places: an unmasked external interrupt line, an interrupt from a peripheral whose clock is still enabled, or the non-maskable interrupt once it has been armed. A wake-up passes through a resume state. In that state, after a STOP, the saved source is put back, and RUN is reported only when that source reports that it is running.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: During and after reset, curMode is RUN (code 0), sysClkSel is 0 (the IRC), ircEn is 1 and every bit of periphClkEn is 1.
- R2: In RUN and in HALT, a select request moves sysClkSel to selReq on the next cycle only if srcRunning bit selReq is set (bit i flags source i, and source 0 is the IRC). Otherwise sysClkSel keeps its value.
- R3: A STOP entry saves the current sysClkSel and drives sysClkSel to 0 on the cycle curMode becomes STOP (code 1). Select requests have no effect while in STOP.
- R4: ircEn is 1 whenever curMode is STOP or HALT (code 2), whatever ircOffReq says. In RUN, ircEn is the inverse of ircOffReq when a non-IRC source is selected, and is 1 when the IRC is selected.
- R5: In STOP and HALT, periphClkEn bit PIN_IDX stays 1. Every other bit is the inverse of its gateMask bit (1 requests gating).
- R6: In STOP or HALT, an extIrq line whose extIrqMask bit is 0 moves curMode to RESUME (code 3) on the next cycle. A masked line has no effect.
- R7: In STOP or HALT, a periphIrq bit wakes the block only when the matching periphClkEn bit is 1. An interrupt from a gated peripheral leaves the mode unchanged.
- R8: Writing nmiEnData=1 with nmiEnWr arms the NMI until the next reset, and later writes of 0 are ignored. An armed NMI wakes the block from STOP or HALT, and an unarmed NMI does not.
- R9: On the wake from STOP, the saved source is restored to sysClkSel, together with RESUME. From RESUME, RUN is entered on the first cycle that the selected source's srcRunning bit is set. All clock enables are 1 from RESUME on.
- R10: A mode request (reqValid with reqHalt: 0 = STOP, 1 = HALT) takes effect one cycle later only from RUN. A request made in any other mode is held (the latest one wins) and takes effect on the cycle after the block is back in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Mode request strobe |
| reqHalt | input | 1 | Requested mode: 0 STOP, 1 HALT |
| selReqValid | input | 1 | Clock source select request strobe |
| selReq | input | SEL_W | Requested clock source index |
| ircOffReq | input | 1 | Software wish to switch the IRC off |
| srcRunning | input | NUM_SRC | Running flag per clock source, bit 0 is the IRC |
| gateMask | input | NUM_PERIPH | Per-peripheral gating request for low-power modes |
| extIrq | input | NUM_EXTI | External interrupt lines |
| extIrqMask | input | NUM_EXTI | 1 masks the matching external line |
| nmiPin | input | 1 | Non-maskable interrupt line |
| nmiEnWr | input | 1 | Write strobe for the NMI arm bit |
| nmiEnData | input | 1 | Value written to the NMI arm bit |
| periphIrq | input | NUM_PERIPH | Peripheral interrupt requests |
| sysClkSel | output | SEL_W | Registered system clock source select |
| ircEn | output | 1 | Registered IRC enable |
| periphClkEn | output | NUM_PERIPH | Registered peripheral clock enables |
| curMode | output | 2 | Current mode: 0 RUN, 1 STOP, 2 HALT, 3 RESUME |

## Verification
The select path is tried with requests toward running and stopped sources, both in RUN and in HALT. This separates a selector that follows requests blindly from one that checks the running flag. The wake paths each get a triggering and a non-triggering case: a masked line against an unmasked one, a gated peripheral against an ungated one, and the NMI before and after it is armed. These pairs show whether each qualifier is actually applied. The resume is held back by clearing the restored source's running flag, so the bench can tell a controller that waits for the flag from one that jumps straight to RUN. A mode request is placed during that wait to show that it is deferred and not lost.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_STOP   = 2'd1,
    MODE_HALT   = 2'd2,
    MODE_RESUME = 2'd3
  } lpmMode_e;

  // strobes from the mode control to the clock datapath
  typedef struct packed {
    logic enterStop;     // RUN -> STOP this cycle
    logic enterHalt;     // RUN -> HALT this cycle
    logic wakeFromStop;  // STOP -> RESUME this cycle
    logic selAllowed;    // a select request may be honoured this cycle
    logic nextRun;       // next mode is RUN
    logic nextLowPower;  // next mode is STOP or HALT
  } lpmStrobe_t;

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_EXTI   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  nmiEnWr,
  input  logic                  nmiEnData,
  input  logic                  nmiPin,
  input  logic [NUM_EXTI-1:0]   extIrq,
  input  logic [NUM_EXTI-1:0]   extIrqMask,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  input  logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  wakeReq,
  output logic                  nmiArmed
);

  logic extHit;
  logic periphHit;

  // arm bit only ever sets; cleared by reset alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiArmed <= 1'b0;
    end else if (nmiEnWr && nmiEnData) begin
      nmiArmed <= 1'b1;
    end
  end

  always_comb begin
    extHit    = |(extIrq & ~extIrqMask);
    periphHit = |(periphIrq & periphClkEn);
    wakeReq   = extHit || periphHit || (nmiArmed && nmiPin);
  end

  // R8: once armed, a zero write cannot disarm
  a_r8_nmi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(nmiArmed) |-> nmiArmed);

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqHalt,
  input  logic       wakeReq,
  input  logic       selRunning,
  output lpmStrobe_t strb,
  output lpmMode_e   curMode
);

  lpmMode_e nextMode;
  logic     pendValid;
  logic     pendHalt;
  logic     actValid;
  logic     actHalt;

  always_comb begin
    actValid = (curMode == MODE_RUN) && (reqValid || pendValid);
    actHalt  = reqValid ? reqHalt : pendHalt;
    nextMode = curMode;
    case (curMode)
      MODE_RUN:    if (actValid)   nextMode = actHalt ? MODE_HALT : MODE_STOP;
      MODE_STOP:   if (wakeReq)    nextMode = MODE_RESUME;
      MODE_HALT:   if (wakeReq)    nextMode = MODE_RESUME;
      MODE_RESUME: if (selRunning) nextMode = MODE_RUN;
      default:                     nextMode = MODE_RUN;
    endcase
  end

  always_comb begin
    strb.enterStop    = actValid && !actHalt;
    strb.enterHalt    = actValid && actHalt;
    strb.wakeFromStop = (curMode == MODE_STOP) && wakeReq;
    strb.selAllowed   = ((curMode == MODE_RUN) && !actValid) || (curMode == MODE_HALT);
    strb.nextRun      = (nextMode == MODE_RUN);
    strb.nextLowPower = (nextMode == MODE_STOP) || (nextMode == MODE_HALT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_RUN;
    end else begin
      curMode <= nextMode;
    end
  end

  // a request seen outside RUN waits here; the newest one is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendHalt  <= 1'b0;
    end else if (curMode == MODE_RUN) begin
      pendValid <= 1'b0;
    end else if (reqValid) begin
      pendValid <= 1'b1;
      pendHalt  <= reqHalt;
    end
  end

  // R10: low-power modes are entered from RUN only
  a_r10_entry_from_run: assert property (@(posedge clk) disable iff (!rstN)
    (((curMode == MODE_STOP) || (curMode == MODE_HALT)) && (curMode != $past(curMode)))
      |-> ($past(curMode) == MODE_RUN));

  // R9: resume waits while the selected source is not running
  a_r9_resume_waits: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode == MODE_RESUME) && !selRunning) |=> (curMode == MODE_RESUME));

endmodule

// File: rtl/lpm_clk_datapath.sv
module lpm_clk_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int NUM_PERIPH = 8,
  parameter int PIN_IDX    = 0,
  localparam int SEL_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lpmStrobe_t            strb,
  input  logic                  selReqValid,
  input  logic [SEL_W-1:0]      selReq,
  input  logic                  ircOffReq,
  input  logic [NUM_SRC-1:0]    srcRunning,
  input  logic [NUM_PERIPH-1:0] gateMask,
  output logic [SEL_W-1:0]      sysClkSel,
  output logic                  ircEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  selRunning
);

  localparam logic [SEL_W-1:0] IRC_SEL = '0;

  logic [SEL_W-1:0]      savedSel;
  logic [SEL_W-1:0]      nextSel;
  logic                  reqRunning;
  logic                  selOk;
  logic                  ircNext;
  logic [NUM_PERIPH-1:0] lpEnable;
  logic [NUM_PERIPH-1:0] clkEnNext;

  // running flag lookup for the requested and the current source
  always_comb begin
    reqRunning = 1'b0;
    selRunning = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (selReq == SEL_W'(i))    reqRunning = srcRunning[i];
      if (sysClkSel == SEL_W'(i)) selRunning = srcRunning[i];
    end
  end

  always_comb begin
    selOk   = selReqValid && strb.selAllowed && reqRunning;
    nextSel = sysClkSel;
    if (strb.enterStop) begin
      nextSel = IRC_SEL;
    end else if (strb.wakeFromStop) begin
      nextSel = savedSel;
    end else if (selOk) begin
      nextSel = selReq;
    end
    ircNext = strb.nextRun ? !(ircOffReq && (nextSel != IRC_SEL)) : 1'b1;
  end

  // low-power enables: the pin/interrupt peripheral is never gated
  for (genvar g = 0; g < NUM_PERIPH; g++) begin : gen_gate
    if (g == PIN_IDX) begin : gen_keep
      assign lpEnable[g] = 1'b1;
    end else begin : gen_mask
      assign lpEnable[g] = ~gateMask[g];
    end
  end

  assign clkEnNext = strb.nextLowPower ? lpEnable : {NUM_PERIPH{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysClkSel   <= IRC_SEL;
      savedSel    <= IRC_SEL;
      ircEn       <= 1'b1;
      periphClkEn <= {NUM_PERIPH{1'b1}};
    end else begin
      sysClkSel   <= nextSel;
      ircEn       <= ircNext;
      periphClkEn <= clkEnNext;
      if (strb.enterStop) begin
        savedSel <= sysClkSel;
      end
    end
  end

  // R2: a selection granted through a request always lands on a source that was running
  a_r2_grant_running: assert property (@(posedge clk) disable iff (!rstN)
    (selReqValid && strb.selAllowed && !strb.enterStop && !strb.wakeFromStop && !reqRunning)
      |=> (sysClkSel == $past(sysClkSel)));

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int NUM_PERIPH = 8,
  parameter int NUM_EXTI   = 4,
  parameter int PIN_IDX    = 0,
  localparam int SEL_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqHalt,
  input  logic                  selReqValid,
  input  logic [SEL_W-1:0]      selReq,
  input  logic                  ircOffReq,
  input  logic [NUM_SRC-1:0]    srcRunning,
  input  logic [NUM_PERIPH-1:0] gateMask,
  input  logic [NUM_EXTI-1:0]   extIrq,
  input  logic [NUM_EXTI-1:0]   extIrqMask,
  input  logic                  nmiPin,
  input  logic                  nmiEnWr,
  input  logic                  nmiEnData,
  input  logic [NUM_PERIPH-1:0] periphIrq,
  output logic [SEL_W-1:0]      sysClkSel,
  output logic                  ircEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic [1:0]            curMode
);

  lpmStrobe_t strb;
  lpmMode_e   modeQ;
  logic       wakeReq;
  logic       nmiArmed;
  logic       selRunning;

  lpm_wake_detect #(
    .NUM_PERIPH(NUM_PERIPH),
    .NUM_EXTI  (NUM_EXTI)
  ) u_wake (
    .clk        (clk),
    .rstN       (rstN),
    .nmiEnWr    (nmiEnWr),
    .nmiEnData  (nmiEnData),
    .nmiPin     (nmiPin),
    .extIrq     (extIrq),
    .extIrqMask (extIrqMask),
    .periphIrq  (periphIrq),
    .periphClkEn(periphClkEn),
    .wakeReq    (wakeReq),
    .nmiArmed   (nmiArmed)
  );

  lpm_mode_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqHalt   (reqHalt),
    .wakeReq   (wakeReq),
    .selRunning(selRunning),
    .strb      (strb),
    .curMode   (modeQ)
  );

  lpm_clk_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_PERIPH(NUM_PERIPH),
    .PIN_IDX   (PIN_IDX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .selReqValid(selReqValid),
    .selReq     (selReq),
    .ircOffReq  (ircOffReq),
    .srcRunning (srcRunning),
    .gateMask   (gateMask),
    .sysClkSel  (sysClkSel),
    .ircEn      (ircEn),
    .periphClkEn(periphClkEn),
    .selRunning (selRunning)
  );

  assign curMode = modeQ;

  // one-cycle copy of the running flags, used only by the checks below
  logic [NUM_SRC-1:0] runD;
  always_ff @(posedge clk) runD <= srcRunning;

  logic lowPower;
  assign lowPower = (modeQ == MODE_STOP) || (modeQ == MODE_HALT);

  // R3: STOP always runs from the IRC
  a_r3_stop_on_irc: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_STOP) |-> (sysClkSel == '0));

  // R4: IRC stays powered in both low-power modes
  a_r4_irc_kept: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> ircEn);

  // R5: pin/interrupt peripheral clock never gated in low power
  a_r5_pin_clock: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> periphClkEn[PIN_IDX]);

  // R2: in HALT the selector only moves to a source that was running
  a_r2_halt_running: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_HALT) && ($past(modeQ) == MODE_HALT) && (sysClkSel != $past(sysClkSel)))
      |-> runD[sysClkSel]);

  // R6: an unmasked external line in low power leads to RESUME
  a_r6_ext_wake: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && |(extIrq & ~extIrqMask)) |=> (modeQ == MODE_RESUME));

  // R9: RUN is reported after resume only with a running source
  a_r9_run_running: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_RUN) && ($past(modeQ) == MODE_RESUME)) |-> runD[sysClkSel]);

endmodule

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;

  localparam int NUM_SRC    = 4;
  localparam int NUM_PERIPH = 8;
  localparam int NUM_EXTI   = 4;
  localparam int SEL_W      = 2;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0, reqHalt = 1'b0;
  logic                  selReqValid = 1'b0;
  logic [SEL_W-1:0]      selReq = '0;
  logic                  ircOffReq = 1'b0;
  logic [NUM_SRC-1:0]    srcRunning = '1;
  logic [NUM_PERIPH-1:0] gateMask = '0;
  logic [NUM_EXTI-1:0]   extIrq = '0, extIrqMask = '0;
  logic                  nmiPin = 1'b0, nmiEnWr = 1'b0, nmiEnData = 1'b0;
  logic [NUM_PERIPH-1:0] periphIrq = '0;
  logic [SEL_W-1:0]      sysClkSel;
  logic                  ircEn;
  logic [NUM_PERIPH-1:0] periphClkEn;
  logic [1:0]            curMode;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  lpm_clk_ctrl #(.NUM_SRC(NUM_SRC), .NUM_PERIPH(NUM_PERIPH), .NUM_EXTI(NUM_EXTI), .PIN_IDX(0)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHalt(reqHalt),
    .selReqValid(selReqValid), .selReq(selReq), .ircOffReq(ircOffReq),
    .srcRunning(srcRunning), .gateMask(gateMask), .extIrq(extIrq),
    .extIrqMask(extIrqMask), .nmiPin(nmiPin), .nmiEnWr(nmiEnWr),
    .nmiEnData(nmiEnData), .periphIrq(periphIrq), .sysClkSel(sysClkSel),
    .ircEn(ircEn), .periphClkEn(periphClkEn), .curMode(curMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs change on falling edges; one step crosses exactly one rising edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modeReq(input logic halt);
    reqValid = 1'b1; reqHalt = halt;
    step(1);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(curMode), 0);
    chk("R1 sel", 32'(sysClkSel), 0);
    chk("R1 irc", 32'(ircEn), 1);
    chk("R1 clkEn", 32'(periphClkEn), 32'hFF);
  endtask

  task automatic t_run_select();
    selReqValid = 1'b1; selReq = 2'd2;
    step(1);
    chk("R2 run select running", 32'(sysClkSel), 2);
    srcRunning = 4'b0111; selReq = 2'd3;
    step(1);
    chk("R2 run select stopped rejected", 32'(sysClkSel), 2);
    selReqValid = 1'b0; srcRunning = 4'b1111;
  endtask

  task automatic t_irc_run();
    ircOffReq = 1'b1;
    step(1);
    chk("R4 run irc off honoured", 32'(ircEn), 0);
    selReqValid = 1'b1; selReq = 2'd0;
    step(1);
    chk("R4 run irc kept when selected", 32'(ircEn), 1);
    selReq = 2'd2;
    step(1);
    selReqValid = 1'b0;
    chk("R4 run irc off again", 32'(ircEn), 0);
  endtask

  task automatic t_stop();
    gateMask = 8'hFF;
    modeReq(1'b0);
    chk("R10 stop entered", 32'(curMode), 1);
    chk("R3 stop sel irc", 32'(sysClkSel), 0);
    chk("R4 stop irc forced", 32'(ircEn), 1);
    chk("R5 stop pin clock kept", 32'(periphClkEn), 32'h01);
    selReqValid = 1'b1; selReq = 2'd1;
    step(1);
    selReqValid = 1'b0;
    chk("R3 stop select ignored", 32'(sysClkSel), 0);
    periphIrq = 8'h08;
    step(1);
    periphIrq = '0;
    chk("R7 gated periph no wake", 32'(curMode), 1);
    extIrqMask = 4'b0001; extIrq = 4'b0001;
    step(1);
    chk("R6 masked line no wake", 32'(curMode), 1);
    srcRunning = 4'b1011; extIrq = 4'b0100;
    step(1);
    extIrq = '0;
    chk("R6 unmasked wake", 32'(curMode), 3);
    chk("R9 saved sel restored", 32'(sysClkSel), 2);
    chk("R9 clocks on in resume", 32'(periphClkEn), 32'hFF);
    step(1);
    chk("R9 wait for running", 32'(curMode), 3);
    srcRunning = 4'b1111;
    step(1);
    chk("R9 run after running", 32'(curMode), 0);
    chk("R4 run irc off after resume", 32'(ircEn), 0);
  endtask

  task automatic t_halt();
    gateMask = 8'hDF;
    modeReq(1'b1);
    chk("R10 halt entered", 32'(curMode), 2);
    chk("R2 halt keeps sel", 32'(sysClkSel), 2);
    chk("R4 halt irc forced", 32'(ircEn), 1);
    chk("R5 halt enables", 32'(periphClkEn), 32'h21);
    srcRunning = 4'b1101; selReqValid = 1'b1; selReq = 2'd1;
    step(1);
    chk("R2 halt stopped source rejected", 32'(sysClkSel), 2);
    selReq = 2'd3;
    step(1);
    selReqValid = 1'b0;
    chk("R2 halt running source taken", 32'(sysClkSel), 3);
    periphIrq = 8'h20;
    step(1);
    periphIrq = '0;
    chk("R7 ungated periph wake", 32'(curMode), 3);
    step(1);
    chk("R9 halt resume to run", 32'(curMode), 0);
    srcRunning = 4'b1111;
  endtask

  task automatic t_nmi();
    modeReq(1'b0);
    nmiPin = 1'b1;
    step(1);
    nmiPin = 1'b0;
    chk("R8 unarmed nmi no wake", 32'(curMode), 1);
    nmiEnWr = 1'b1; nmiEnData = 1'b1;
    step(1);
    nmiEnData = 1'b0;
    step(1);
    nmiEnWr = 1'b0;
    chk("R8 still stop", 32'(curMode), 1);
    nmiPin = 1'b1;
    step(1);
    nmiPin = 1'b0;
    chk("R8 armed nmi wake despite zero write", 32'(curMode), 3);
    step(1);
    chk("R9 nmi resume to run", 32'(curMode), 0);
    chk("R9 restored sel", 32'(sysClkSel), 3);
  endtask

  task automatic t_pending();
    modeReq(1'b0);
    srcRunning = 4'b0111;
    extIrq = 4'b0010;
    step(1);
    extIrq = '0;
    chk("R9 resume held", 32'(curMode), 3);
    modeReq(1'b1);
    chk("R10 request not acted in resume", 32'(curMode), 3);
    step(1);
    chk("R10 still resume", 32'(curMode), 3);
    srcRunning = 4'b1111;
    step(1);
    chk("R10 back in run first", 32'(curMode), 0);
    step(1);
    chk("R10 held request acted", 32'(curMode), 2);
    extIrq = 4'b0010;
    step(1);
    extIrq = '0;
    step(1);
    chk("R6 halt wake to run", 32'(curMode), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rstN = 1'b1;
    step(1);
    t_reset();
    t_run_select();
    t_irc_run();
    t_stop();
    t_halt();
    t_nmi();
    t_pending();
    step(2);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule